// File: doc/BRIEF.md
# Coalescing Host Interrupt Controller

This block merges event pulses from many internal sources into one level-sensitive interrupt line toward a host processor. Each source sets a bit in a main status register. The host clears a bit by writing one to it. A per-bit enable mask decides which status bits can raise the line. A separate DMA sub-status register keeps per-channel DMA events, and the block also sets fixed summary bits in the main status from those events.

The line is rate-limited by a coalescing timer. The timer counts an external strobe that marks each 32 µs unit, so one 8-bit limit spans up to about 8 ms. A high-priority receive event from the DMA side bypasses the timer. A second byte in the coalescing register sets a periodic receive event, which is generated from the same strobe. The host uses simple write and read strobes on four word registers: main status at word 0, enable mask at word 1, DMA sub-status at word 2, and coalescing at word 3.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: Main status bits are set by event pulses on `evt_i`. Writing 1 to a bit at word 0 clears it. Writing 0 leaves it unchanged. A set and a clear of the same bit in the same cycle leave the bit set.
- R2: The line `irq_o` considers only status bits whose enable bit at word 1 is 1. A pending bit that is disabled never raises the line.
- R3: A DMA event on bit 31 sets main bit 29. Events on bits 17, 16 or 30 set main bit 31. Events on bits 1 or 0 set main bit 27. These bits are set on the same clock edge as the DMA sub-status bit.
- R4: DMA sub-status bits at word 2 are set by `dma_evt_i` and cleared by writing 1. Clearing a DMA sub-status bit does not clear any main status bit.
- R5: When the coalescing limit (word 3, bits 7:0) is 0, `irq_o` follows the enabled pending status on the same edge that updates the status.
- R6: When the limit N is not 0, the first enabled event while the line is low starts the timer. The line rises on the edge of the Nth `tick_i` strobe after that event, provided enabled status is still pending.
- R7: A DMA event on bit 30, with main bit 31 enabled, raises `irq_o` on the same edge, whatever the coalescing limit is.
- R8: The periodic byte (word 3, bits 15:8) equal to P, with P not 0, sets main bit 28 on every Pth `tick_i` strobe. P = 0 disables the periodic event. Writing word 3 restarts the period count.
- R9: `irq_o` falls on the edge at which no enabled status bit remains pending.
- R10: Only status bits 31, 29 to 25, 7, 6, 3, 1 and 0 exist (mask 0xBE0000CB). Only DMA bits 31, 30, 17, 16, 1 and 0 exist (mask 0xC0030003). Other bits read 0 and cannot be set.
- R11: If the pending status is cleared before the timer expires, the line stays low when the timer expires.
- R12: After reset, status, mask and DMA sub-status read 0, word 3 reads 0x00000040, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| evt_i | input | 32 | Event pulses into the main status |
| dma_evt_i | input | 32 | DMA event pulses into the sub-status |
| tick_i | input | 1 | Strobe for one 32 µs time unit |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
The coalescing limit is swept over several small values. For each value, the line is checked one tick before expiry and again on the expiring tick, which shows that the count is exact and does not stop one tick early or late. Each DMA channel bit is applied alone, so each folding target and the independence of the two clear paths are seen separately. A high-priority event and an ordinary receive event are applied under the same long limit; the first must raise the line at once and the second must not. Further cases cover an event cleared before expiry, a masked event that is later enabled, a full-ones write and a full-ones event to confirm which bits exist, and a periodic setting observed across its period boundary.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned DATA_W = 32;

   // word addresses of the host-visible registers
   localparam logic [1:0] ADR_STAT = 2'd0;
   localparam logic [1:0] ADR_MASK = 2'd1;
   localparam logic [1:0] ADR_DMA  = 2'd2;
   localparam logic [1:0] ADR_COAL = 2'd3;

   // main status summary positions fed by the DMA folding
   localparam int unsigned ST_RX_SUM  = 31;
   localparam int unsigned ST_DMA_ERR = 29;
   localparam int unsigned ST_PERIOD  = 28;
   localparam int unsigned ST_TX_SUM  = 27;

   // DMA sub-status positions
   localparam int unsigned DM_ERR   = 31;
   localparam int unsigned DM_HIPRI = 30;
   localparam int unsigned DM_RX1   = 17;
   localparam int unsigned DM_RX0   = 16;
   localparam int unsigned DM_TX1   = 1;
   localparam int unsigned DM_TX0   = 0;

   localparam logic [DATA_W-1:0] STAT_IMPL_DEF = 32'hBE00_00CB;
   localparam logic [DATA_W-1:0] DMA_IMPL_DEF  = 32'hC003_0003;

   typedef struct packed {
      logic err;
      logic rx;
      logic tx;
      logic hipri;
   } dma_fold_t;
endpackage

// File: rtl/irqc_w1c_reg.sv
module irqc_w1c_reg #(
   parameter int unsigned          W    = 32,
   parameter logic [W-1:0]         IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o,
   output logic [W-1:0] nxt_o
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      if (IMPL[b]) begin : g_impl
         logic bit_q;
         // a set on the same edge as a clear wins
         assign nxt_o[b] = set_i[b] | (bit_q & ~clr_i[b]);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= nxt_o[b];
         end
         assign q_o[b] = bit_q;
      end else begin : g_absent
         assign nxt_o[b] = 1'b0;
         assign q_o[b]   = 1'b0;
      end
   end
endmodule

// File: rtl/irqc_dma_fold.sv
module irqc_dma_fold
   import irqc_pkg::*;
#(
   parameter int unsigned        W    = 32,
   parameter logic [W-1:0]       IMPL = DMA_IMPL_DEF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o,
   output dma_fold_t    fold_o
);
   logic [W-1:0] evt_g;
   logic [W-1:0] nxt_unused;

   assign evt_g = evt_i & IMPL;

   irqc_w1c_reg #(.W(W), .IMPL(IMPL)) u_sub (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_g),
      .clr_i (clr_i),
      .q_o   (q_o),
      .nxt_o (nxt_unused)
   );

   // folding works on the incoming pulses, so clearing the sub-status
   // never touches the summary bits
   assign fold_o.err   = evt_g[DM_ERR];
   assign fold_o.rx    = evt_g[DM_RX1] | evt_g[DM_RX0] | evt_g[DM_HIPRI];
   assign fold_o.tx    = evt_g[DM_TX1] | evt_g[DM_TX0];
   assign fold_o.hipri = evt_g[DM_HIPRI];
endmodule

// File: rtl/irqc_periodic.sv
module irqc_periodic #(
   parameter int unsigned PER_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             restart_i,
   input  logic [PER_W-1:0] period_i,
   output logic             pulse_o
);
   logic [PER_W-1:0] cnt_q;
   logic             active;
   logic             wrap;

   assign active  = (period_i != '0);
   assign wrap    = (cnt_q == period_i - 1'b1);
   assign pulse_o = tick_i & active & wrap & ~restart_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (restart_i || !active) cnt_q <= '0;
      else if (tick_i) begin
         if (wrap) cnt_q <= '0;
         else      cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/irqc_coalesce.sv
module irqc_coalesce #(
   parameter int unsigned COAL_W       = 8,
   parameter bit          HIPRI_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [COAL_W-1:0] limit_i,
   input  logic              pend_nxt_i,
   input  logic              hipri_i,
   output logic              irq_o
);
   logic              irq_q;
   logic              run_q;
   logic [COAL_W-1:0] cnt_q;
   logic              bypass;

   if (HIPRI_BYPASS) begin : g_bypass
      assign bypass = hipri_i;
   end else begin : g_no_bypass
      assign bypass = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (bypass) begin
         irq_q <= 1'b1;
         run_q <= 1'b0;
      end else if (irq_q) begin
         if (!pend_nxt_i) irq_q <= 1'b0;
      end else if (limit_i == '0) begin
         irq_q <= pend_nxt_i;
         run_q <= 1'b0;
      end else if (run_q) begin
         if (tick_i) begin
            if (cnt_q <= 1) begin
               run_q <= 1'b0;
               irq_q <= pend_nxt_i;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end else if (pend_nxt_i) begin
         run_q <= 1'b1;
         cnt_q <= limit_i;
      end
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned          COAL_W       = 8,
   parameter int unsigned          PER_W        = 8,
   parameter logic [COAL_W-1:0]    COAL_RST     = 8'h40,
   parameter bit                   HIPRI_BYPASS = 1'b1,
   parameter logic [DATA_W-1:0]    STAT_IMPL    = STAT_IMPL_DEF,
   parameter logic [DATA_W-1:0]    DMA_IMPL     = DMA_IMPL_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] evt_i,
   input  logic [DATA_W-1:0] dma_evt_i,
   input  logic              tick_i,
   output logic              irq_o
);
   localparam int unsigned PER_LSB = 8;

   if (COAL_W < 1 || COAL_W > 8) begin : g_bad_coal
      $error("COAL_W must be 1..8");
   end
   if (PER_W < 1 || PER_W > 8) begin : g_bad_per
      $error("PER_W must be 1..8");
   end
   if (!STAT_IMPL[ST_RX_SUM] || !STAT_IMPL[ST_DMA_ERR] ||
       !STAT_IMPL[ST_TX_SUM] || !STAT_IMPL[ST_PERIOD]) begin : g_bad_impl
      $error("summary status bits must be implemented");
   end

   logic              wr_stat, wr_mask, wr_dma, wr_coal;
   logic [DATA_W-1:0] status_q, status_nxt, stat_set;
   logic [DATA_W-1:0] mask_q, mask_nxt;
   logic [DATA_W-1:0] dma_q;
   logic [COAL_W-1:0] coal_q;
   logic [PER_W-1:0]  per_q;
   dma_fold_t         fold;
   logic              per_pulse;
   logic              pend_nxt;
   logic              hipri;

   assign wr_stat = wr_en && (addr == ADR_STAT);
   assign wr_mask = wr_en && (addr == ADR_MASK);
   assign wr_dma  = wr_en && (addr == ADR_DMA);
   assign wr_coal = wr_en && (addr == ADR_COAL);

   irqc_dma_fold #(.W(DATA_W), .IMPL(DMA_IMPL)) u_dma (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (dma_evt_i),
      .clr_i  (wr_dma ? wr_data : '0),
      .q_o    (dma_q),
      .fold_o (fold)
   );

   irqc_periodic #(.PER_W(PER_W)) u_per (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .restart_i (wr_coal),
      .period_i  (per_q),
      .pulse_o   (per_pulse)
   );

   always_comb begin
      stat_set              = evt_i & STAT_IMPL;
      stat_set[ST_DMA_ERR]  = stat_set[ST_DMA_ERR] | fold.err;
      stat_set[ST_RX_SUM]   = stat_set[ST_RX_SUM]  | fold.rx;
      stat_set[ST_TX_SUM]   = stat_set[ST_TX_SUM]  | fold.tx;
      stat_set[ST_PERIOD]   = stat_set[ST_PERIOD]  | per_pulse;
   end

   irqc_w1c_reg #(.W(DATA_W), .IMPL(STAT_IMPL)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (stat_set),
      .clr_i (wr_stat ? wr_data : '0),
      .q_o   (status_q),
      .nxt_o (status_nxt)
   );

   assign mask_nxt = wr_mask ? (wr_data & STAT_IMPL) : mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         coal_q <= COAL_RST;
         per_q  <= '0;
      end else begin
         mask_q <= mask_nxt;
         if (wr_coal) begin
            coal_q <= wr_data[COAL_W-1:0];
            per_q  <= wr_data[PER_LSB +: PER_W];
         end
      end
   end

   assign pend_nxt = |(status_nxt & mask_nxt);
   assign hipri    = fold.hipri & mask_nxt[ST_RX_SUM];

   irqc_coalesce #(.COAL_W(COAL_W), .HIPRI_BYPASS(HIPRI_BYPASS)) u_coal (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .limit_i    (coal_q),
      .pend_nxt_i (pend_nxt),
      .hipri_i    (hipri),
      .irq_o      (irq_o)
   );

   always_comb begin
      rd_data = '0;
      unique case (addr)
         ADR_STAT: rd_data = status_q;
         ADR_MASK: rd_data = mask_q;
         ADR_DMA:  rd_data = dma_q;
         ADR_COAL: begin
            rd_data[COAL_W-1:0]         = coal_q;
            rd_data[PER_LSB +: PER_W]   = per_q;
         end
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int unsigned COAL_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        addr,
   input logic [31:0]       dma_evt_i,
   input logic              irq_o,
   input logic [31:0]       status_q,
   input logic [31:0]       mask_q,
   input logic [COAL_W-1:0] coal_q
);
   logic pending;
   assign pending = |(status_q & mask_q);

   // without a status write, no status bit may drop
   assert_no_silent_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == 2'd0) |=> ((status_q & $past(status_q)) == $past(status_q)));

   assert_dma_err_fold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dma_evt_i[31] |=> status_q[29]);

   assert_zero_limit_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(coal_q) == '0 && coal_q == '0) |-> (irq_o == pending));

   assert_hipri_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_evt_i[30] && mask_q[31] && !wr_en) |=> irq_o);

   assert_line_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> pending);
endmodule

bind irq_coalesce_ctrl irqc_checker #(.COAL_W(COAL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .addr      (addr),
   .dma_evt_i (dma_evt_i),
   .irq_o     (irq_o),
   .status_q  (status_q),
   .mask_q    (mask_q),
   .coal_q    (coal_q)
);

// File: tb/irq_coalesce_ctrl_tb.sv
`timescale 1ns/1ps
module irq_coalesce_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [31:0] evt_i = '0;
   logic [31:0] dma_evt_i = '0;
   logic        tick_i = 1'b0;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_coalesce_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .evt_i(evt_i),
      .dma_evt_i(dma_evt_i), .tick_i(tick_i), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      addr = a; #0.5; d = rd_data;
   endtask

   task automatic evt(input logic [31:0] v);
      @(negedge clk); evt_i = v;
      @(negedge clk); evt_i = '0;
   endtask

   task automatic devt(input logic [31:0] v);
      @(negedge clk); dma_evt_i = v;
      @(negedge clk); dma_evt_i = '0;
   endtask

   task automatic tick();
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
   endtask

   task automatic clear_all();
      wr(2'd0, 32'hFFFF_FFFF);
      wr(2'd2, 32'hFFFF_FFFF);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   function automatic logic [31:0] fold_of(input int b);
      case (b)
         31:        return 32'h2000_0000;
         30, 17, 16: return 32'h8000_0000;
         default:   return 32'h0800_0000;
      endcase
   endfunction

   initial begin
      #100000;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset values
      rd(2'd0, r); chk("R12 status", r, 32'h0);
      rd(2'd1, r); chk("R12 mask", r, 32'h0);
      rd(2'd2, r); chk("R12 dma", r, 32'h0);
      rd(2'd3, r); chk("R12 coal", r, 32'h40);
      chk("R12 irq", {31'b0, irq_o}, 32'h0);

      // R10 implemented bits
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, r); chk("R10 mask bits", r, 32'hBE00_00CB);
      wr(2'd1, 32'h0);
      evt(32'hFFFF_FFFF);
      rd(2'd0, r); chk("R10 status bits", r, 32'hBE00_00CB);
      devt(32'hFFFF_FFFF);
      rd(2'd2, r); chk("R10 dma bits", r, 32'hC003_0003);
      clear_all();

      // R1 write-one-to-clear
      evt(32'h0000_0048);
      wr(2'd0, 32'h0);
      rd(2'd0, r); chk("R1 write zero", r, 32'h48);
      wr(2'd0, 32'h8);
      rd(2'd0, r); chk("R1 write one", r, 32'h40);
      @(negedge clk); addr = 2'd0; wr_data = 32'h40; wr_en = 1'b1; evt_i = 32'h40;
      @(negedge clk); wr_en = 1'b0; evt_i = '0;
      rd(2'd0, r); chk("R1 set beats clear", r, 32'h40);
      clear_all();

      // R2 / R5 mask with zero limit
      wr(2'd3, 32'h0);
      evt(32'h0000_0040);
      chk("R2 masked no irq", {31'b0, irq_o}, 32'h0);
      wr(2'd1, 32'h0000_0040);
      chk("R5 irq on enable", {31'b0, irq_o}, 32'h1);
      wr(2'd0, 32'h40);
      chk("R9 irq falls", {31'b0, irq_o}, 32'h0);
      evt(32'h0000_0040);
      chk("R5 immediate", {31'b0, irq_o}, 32'h1);
      clear_all();
      wr(2'd1, 32'h0);

      // R3 / R4 each DMA channel alone
      foreach (r[i]) begin end
      for (int k = 0; k < 6; k++) begin
         int b;
         b = (k == 0) ? 31 : (k == 1) ? 30 : (k == 2) ? 17 : (k == 3) ? 16 : (k == 4) ? 1 : 0;
         devt(32'h1 << b);
         rd(2'd2, r); chk("R4 dma set", r, 32'h1 << b);
         rd(2'd0, r); chk("R3 fold", r, fold_of(b));
         wr(2'd2, 32'h1 << b);
         rd(2'd2, r); chk("R4 dma clear", r, 32'h0);
         rd(2'd0, r); chk("R4 main kept", r, fold_of(b));
         wr(2'd0, 32'hFFFF_FFFF);
      end

      // R6 limit sweep
      wr(2'd1, 32'h1);
      for (int n = 1; n <= 5; n++) begin
         wr(2'd3, n);
         evt(32'h1);
         chk("R6 not at event", {31'b0, irq_o}, 32'h0);
         for (int t = 1; t < n; t++) tick();
         chk("R6 before expiry", {31'b0, irq_o}, 32'h0);
         tick();
         chk("R6 at expiry", {31'b0, irq_o}, 32'h1);
         wr(2'd0, 32'h1);
         chk("R9 cleared", {31'b0, irq_o}, 32'h0);
      end

      // R11 cleared before expiry
      wr(2'd3, 32'h3);
      evt(32'h1);
      wr(2'd0, 32'h1);
      repeat (3) tick();
      chk("R11 no irq", {31'b0, irq_o}, 32'h0);
      repeat (4) tick();
      chk("R11 still low", {31'b0, irq_o}, 32'h0);

      // R7 high priority bypass versus ordinary rx
      wr(2'd3, 32'd200);
      wr(2'd1, 32'h8000_0000);
      devt(32'h0001_0000);
      chk("R7 ordinary rx waits", {31'b0, irq_o}, 32'h0);
      clear_all();
      devt(32'h4000_0000);
      chk("R7 hipri immediate", {31'b0, irq_o}, 32'h1);
      clear_all();
      chk("R9 hipri cleared", {31'b0, irq_o}, 32'h0);
      wr(2'd1, 32'h0);

      // R8 periodic
      for (int p = 1; p <= 3; p++) begin
         wr(2'd3, p << 8);
         for (int t = 1; t < p; t++) tick();
         rd(2'd0, r); chk("R8 before period", r & 32'h1000_0000, 32'h0);
         tick();
         rd(2'd0, r); chk("R8 at period", r & 32'h1000_0000, 32'h1000_0000);
         wr(2'd0, 32'h1000_0000);
      end
      wr(2'd3, 32'h0);
      repeat (4) tick();
      rd(2'd0, r); chk("R8 disabled", r, 32'h0);

      finish_run();
   end
endmodule